// File: doc/BRIEF.md
# Power-Management Interval Timer

This block is a free-running interval timer for system power management. It counts one step for every cycle in which an external tick enable is high. That enable is produced elsewhere at the standard power-management rate of 3,579,545 Hz. Software reads the count one byte at a time through a 256-byte I/O window. The window can be moved anywhere in I/O space, and it can be switched on or off.

Two configuration bytes control the timer. Both are reached in configuration space over the same byte-wide bus. The mode byte sits at configuration offset 0x41. Its bit 7 switches the window on. Its bit 3 selects full-width reads; when bit 3 is clear, software sees only the narrow low part of the count. The base byte sits at configuration offset 0x49. It gives the high byte of the window address. The count is always kept at full width. Only the view through the window is cut to the narrow width.

A read strobe is answered on the following clock edge with a data byte and a hit flag. When there is no hit, the data is held at zero so that other responders on the bus can be ORed in.

Top module: `pm_interval_timer`

## Requirements
- R1: After reset the counter, the mode byte and the base byte are all zero, and the hit output is low.
- R2: The counter increases by exactly one at every clock edge where tickEn is high. It holds otherwise, and it wraps modulo 2^CNT_W (CNT_W defaults to 32).
- R3: A configuration-space write (busCfg=1) stores busWdata at offset 0x41 (mode) or 0x49 (base). A configuration read of either offset returns the stored byte with a hit. Any other configuration offset gives no hit and data 0.
- R4: An I/O read (busCfg=0) hits the window only when mode bit 7 is set, the base byte is nonzero, and busAddr[15:8] equals the base byte.
- R5: Inside the window, offset 0x08+k returns byte k of the visible count, least significant byte first, for k from 0 to CNT_W/8-1. The value returned is the count before any tick that falls in the same cycle as the read.
- R6: With mode bit 3 clear, count bits at position NARROW_W (default 24) and above read as zero. With bit 3 set, all CNT_W bits are visible.
- R7: Any other offset inside an active window returns 0xFF with a hit.
- R8: I/O writes inside the window change neither the counter nor the configuration bytes.
- R9: Reads outside the window, or while the window is off, give no hit and data 0.
- R10: Read data and hit appear at the clock edge that samples busRd and last one cycle. At all other times hit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulses at the timer rate |
| busCfg | input | 1 | 1 = configuration space, 0 = I/O space |
| busAddr | input | 16 | Byte address; configuration accesses use bits 7:0 |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, zero when there is no hit |
| busHit | output | 1 | Read was claimed by this block |

## Verification
A timer-byte read and a tick can fall in the same clock cycle. The design must return the count as it stood before the increment, and the next read must show the increment. The bench provokes this by holding tickEn high during window reads. It also provokes it inside long tick runs that cross the narrow-width boundary and the full wrap. The scoreboard judges each returned byte against a model that captures the expected value before it applies that cycle's tick.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int MODE_WIDE_BIT = 3;
  localparam int MODE_IOEN_BIT = 7;
  localparam logic [7:0] CFG_MODE_OFS = 8'h41;
  localparam logic [7:0] CFG_BASE_OFS = 8'h49;
  localparam logic [7:0] TIMER_OFS    = 8'h08;
  localparam logic [7:0] FILL_BYTE    = 8'hFF;

  // strobes from control to datapath for one bus cycle
  typedef struct packed {
    logic       rdTimer;
    logic       rdFill;
    logic       rdCfg;
    logic [2:0] byteSel;
    logic [7:0] cfgVal;
    logic       wide;
  } pmtStrobes_t;
endpackage

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 8,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCfg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output pmtStrobes_t       strobes
);
  localparam int BASE_W = ADDR_W - WIN_BITS;
  localparam int NBYTES = CNT_W / 8;
  localparam int TIMER_FIRST = int'(TIMER_OFS);
  localparam int TIMER_LAST  = TIMER_FIRST + NBYTES - 1;

  logic [7:0]        modeReg;
  logic [BASE_W-1:0] baseReg;
  logic [7:0]        cfgOfs;
  logic [WIN_BITS-1:0] winOfs;
  logic [BASE_W-1:0] winPage;
  logic winOn, winSel, isTimerOfs, cfgMode, cfgBase;

  assign cfgOfs  = busAddr[7:0];
  assign winOfs  = busAddr[WIN_BITS-1:0];
  assign winPage = busAddr[ADDR_W-1:WIN_BITS];
  assign cfgMode = busCfg && (cfgOfs == CFG_MODE_OFS);
  assign cfgBase = busCfg && (cfgOfs == CFG_BASE_OFS);

  assign winOn      = modeReg[MODE_IOEN_BIT] && (baseReg != '0);
  assign winSel     = !busCfg && winOn && (winPage == baseReg);
  assign isTimerOfs = (int'(winOfs) >= TIMER_FIRST) && (int'(winOfs) <= TIMER_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      baseReg <= '0;
    end else if (busWr) begin
      if (cfgMode) modeReg <= busWdata;
      if (cfgBase) baseReg <= BASE_W'(busWdata);
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.rdTimer = busRd && winSel && isTimerOfs;
    strobes.rdFill  = busRd && winSel && !isTimerOfs;
    strobes.rdCfg   = busRd && (cfgMode || cfgBase);
    strobes.byteSel = 3'(winOfs - WIN_BITS'(TIMER_OFS));
    strobes.cfgVal  = cfgMode ? modeReg : 8'(baseReg);
    strobes.wide    = modeReg[MODE_WIDE_BIT];
  end

  // R8
  io_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busCfg) |=> ($stable(modeReg) && $stable(baseReg)));
  // R3
  mode_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busCfg && (busAddr[7:0] == CFG_MODE_OFS)) |=> (modeReg == $past(busWdata)));
  // R4
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdTimer, strobes.rdFill, strobes.rdCfg}));
  // R9
  window_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeReg[MODE_IOEN_BIT] || (baseReg == '0)) |-> !(strobes.rdTimer || strobes.rdFill));
endmodule

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  pmtStrobes_t strobes,
  output logic [7:0]  rdData,
  output logic        rdHit
);
  localparam int NBYTES = CNT_W / 8;
  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((64'd1 << NARROW_W) - 64'd1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] visible;
  logic [7:0]       cntBytes [NBYTES];
  logic [7:0]       timerByte;
  logic [7:0]       nextData;
  logic             anyRd;

  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (tickEn) cnt <= cnt + 1'b1;
  end

  assign visible = strobes.wide ? cnt : (cnt & NARROW_MASK);

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign cntBytes[g] = visible[8*g +: 8];
  end

  always_comb begin
    timerByte = FILL_BYTE;
    for (int i = 0; i < NBYTES; i++)
      if (int'(strobes.byteSel) == i) timerByte = cntBytes[i];
  end

  assign anyRd = strobes.rdTimer || strobes.rdFill || strobes.rdCfg;

  always_comb begin
    nextData = 8'h00;
    if (strobes.rdTimer)     nextData = timerByte;
    else if (strobes.rdFill) nextData = FILL_BYTE;
    else if (strobes.rdCfg)  nextData = strobes.cfgVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= 8'h00;
      rdHit  <= 1'b0;
    end else begin
      rdData <= nextData;
      rdHit  <= anyRd;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R10
  hit_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> $past(anyRd));
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdHit |-> (rdData == 8'h00));
  // R7
  fill_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && $past(strobes.rdFill)) |-> (rdData == FILL_BYTE));
endmodule

// File: rtl/pm_interval_timer.sv
module pm_interval_timer
  import pmt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 8,
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busCfg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              busHit
);
  pmtStrobes_t strobes;

  pmt_ctrl #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busCfg(busCfg), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata), .strobes(strobes)
  );

  pmt_datapath #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobes(strobes),
    .rdData(busRdata), .rdHit(busHit)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !busHit);
endmodule

// File: tb/pm_interval_timer_test.sv
module pm_interval_timer_test;
  localparam int CNT_W    = 16;
  localparam int NARROW_W = 12;
  localparam int NB       = CNT_W / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, busCfg = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        busHit;

  always #5 clk = ~clk;

  pm_interval_timer #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busCfg(busCfg), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .busHit(busHit)
  );

  typedef struct { logic hit; logic [7:0] data; string tag; } exp_t;
  exp_t expQ[$];
  int nTests = 0, nFail = 0;
  logic done = 1'b0;

  // bench model
  longint unsigned mCnt = 0;
  logic [7:0] mMode = 8'h00, mBase = 8'h00;

  function automatic exp_t predict(logic cfg, logic [15:0] a, string tag);
    exp_t e;
    longint unsigned vis;
    int ofs;
    e.tag = tag; e.hit = 1'b0; e.data = 8'h00;
    if (cfg) begin
      if (a[7:0] == 8'h41) begin e.hit = 1'b1; e.data = mMode; end
      else if (a[7:0] == 8'h49) begin e.hit = 1'b1; e.data = mBase; end
    end else if (mMode[7] && mBase != 0 && a[15:8] == mBase) begin
      e.hit = 1'b1;
      ofs = int'(a[7:0]);
      vis = mMode[3] ? mCnt : (mCnt & ((64'd1 << NARROW_W) - 1));
      if (ofs >= 8 && ofs < 8 + NB) e.data = 8'(vis >> (8 * (ofs - 8)));
      else e.data = 8'hFF;
    end
    return e;
  endfunction

  task automatic step(logic cfg, logic [15:0] a, logic rd, logic wr,
                      logic [7:0] wd, logic tk, string tag);
    @(negedge clk);
    busCfg = cfg; busAddr = a; busRd = rd; busWr = wr; busWdata = wd; tickEn = tk;
    if (rd) expQ.push_back(predict(cfg, a, tag));
    if (wr && cfg) begin
      if (a[7:0] == 8'h41) mMode = wd;
      if (a[7:0] == 8'h49) mBase = wd;
    end
    if (tk) mCnt = (mCnt + 1) % (64'd1 << CNT_W);
  endtask

  task automatic rd(logic cfg, logic [15:0] a, logic tk, string tag);
    step(cfg, a, 1'b1, 1'b0, 8'h00, tk, tag);
  endtask

  task automatic wr(logic cfg, logic [15:0] a, logic [7:0] d, string tag);
    step(cfg, a, 1'b0, 1'b1, d, 1'b0, tag);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b1, "tick");
  endtask

  task automatic idle();
    step(1'b0, 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, "idle");
  endtask

  // monitor / scoreboard
  initial begin
    logic wasRd;
    forever begin
      @(posedge clk);
      wasRd = busRd && rstN;
      @(negedge clk);
      if (wasRd && expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nTests++;
        if (busHit !== e.hit || busRdata !== e.data) begin
          nFail++;
          $display("FAIL %s: got hit=%0b data=%02h, expected hit=%0b data=%02h",
                   e.tag, busHit, busRdata, e.hit, e.data);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    nTests++;
    if (busHit !== 1'b0) begin
      nFail++; $display("FAIL R1 hit in reset: got %0b expected 0", busHit);
    end
    rstN = 1'b1;
    // R1: reset state
    rd(1, 16'h0041, 0, "R1 mode after reset");
    rd(1, 16'h0049, 0, "R1 base after reset");
    rd(0, 16'h0008, 0, "R1 R9 window off after reset");
    // R3: config access
    wr(1, 16'h0049, 8'h12, "base");
    rd(1, 16'h0049, 0, "R3 base readback");
    rd(1, 16'h0040, 0, "R3 unmapped cfg offset");
    rd(1, 16'h1208, 0, "R3 cfg space ignores window");
    rd(0, 16'h1208, 0, "R9 window disabled");
    wr(1, 16'h0041, 8'h80, "mode");
    rd(1, 16'h0041, 0, "R3 mode readback");
    // R5, R10: timer bytes, tick coinciding with read
    ticks(5);
    rd(0, 16'h1208, 0, "R5 byte0");
    rd(0, 16'h1209, 0, "R5 byte1");
    rd(0, 16'h1208, 1, "R5 R10 read with tick");
    rd(0, 16'h1208, 1, "R5 R10 read after tick");
    rd(0, 16'h1208, 0, "R2 count held");
    // R7: other offsets
    rd(0, 16'h1200, 0, "R7 offset 00");
    rd(0, 16'h1207, 0, "R7 offset 07");
    rd(0, 16'h120A, 0, "R7 beyond timer bytes");
    rd(0, 16'h12FF, 0, "R7 offset FF");
    // R4: window decode
    rd(0, 16'h1308, 0, "R4 other page");
    rd(0, 16'h0008, 0, "R9 page zero");
    // R8: window writes ignored
    step(0, 16'h1208, 0, 1, 8'h55, 0, "R8 write");
    step(0, 16'h1241, 0, 1, 8'h00, 0, "R8 write");
    step(0, 16'h1249, 0, 1, 8'h00, 0, "R8 write");
    rd(0, 16'h1208, 0, "R8 count unchanged");
    rd(1, 16'h0041, 0, "R8 mode unchanged");
    rd(1, 16'h0049, 0, "R8 base unchanged");
    // R6: narrow view then wide view
    ticks(5000);
    rd(0, 16'h1209, 0, "R6 narrow byte1");
    rd(0, 16'h1208, 1, "R6 narrow byte0 with tick");
    wr(1, 16'h0041, 8'h88, "mode wide");
    rd(0, 16'h1209, 0, "R6 wide byte1");
    rd(0, 16'h1208, 0, "R6 wide byte0");
    // R2: wrap
    ticks(60600);
    rd(0, 16'h1209, 0, "R2 after wrap byte1");
    rd(0, 16'h1208, 1, "R2 after wrap byte0");
    // R4: zero base with enable
    wr(1, 16'h0049, 8'h00, "base zero");
    rd(0, 16'h0008, 0, "R4 zero base no hit");
    rd(0, 16'h1208, 0, "R4 old page no hit");
    idle(); idle(); idle();
    nTests++;
    if (expQ.size() != 0) begin
      nFail++; $display("FAIL scoreboard: got %0d left, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule